// File: doc/BRIEF.md
# Signed-Digit Radix-10 Multiplier Recoder

This block turns a parallel BCD multiplier operand of `DIGITS` decimal digits into `DIGITS+1` signed decimal digits, each between -5 and +5. Every recoded digit leaves the block as a five-line one-hot magnitude select and a sign line. The magnitude lines name one of the multiples 5X, 4X, 3X, 2X or 1X, and all five lines low means the zero multiple. A row of partial-product multiplexers consumes these selects directly. Any input digit coded 10 to 15 raises a per-digit flag.

Each digit decides alone whether it passes a transfer of +1 to its upper neighbour. The transfer is set when the digit is five or more. The recoded value then needs only the digit itself and the transfer from the digit below, so every position is recoded at once and nothing ripples along the operand. The digit at the least significant end sees no incoming transfer. One extra digit on top takes the transfer leaving the most significant input digit.

Operands enter and results leave on valid/ready handshakes. A word moves when valid and ready are both high at a rising clock edge. A producer holds its word and valid until that edge, and the consumer may hold ready low for any number of cycles. With `REG_OUT` = 1 a single register stage holds one result. With `REG_OUT` = 0 the path is combinational and the handshake passes straight through.

Top module: `sdr10_recoder`

## Requirements
- R1: For input digit Y_i (bits 4i+3..4i of `in_bcd`), let t_i = 1 when Y_i >= 5, else 0, and let t_-1 = 0. Output digit i (0 <= i < DIGITS) carries the value Y_i + t_(i-1) - 10*t_i.
- R2: The magnitude of output digit i is `out_mag[5i+4:5i]`, one-hot. Bit 5i+k set means |value| = k+1, for k = 0..4. All five bits are zero when the value is 0.
- R3: `out_neg[i]` is 1 exactly when output digit i is negative. It is never 1 while that digit's magnitude field is zero.
- R4: Output digit DIGITS (the extra top digit) equals t_(DIGITS-1). Its magnitude field is 00001 or 00000, and its sign bit is always 0.
- R5: When every input digit is valid BCD, the sum over i = 0..DIGITS of value_i * 10^i equals the decimal number held in `in_bcd`.
- R6: `out_bad[i]` is 1 exactly when input digit i is coded 10..15. That digit's magnitude field and sign bit are then 0. It still sends t_i = 1 to its upper neighbour.
- R7: With REG_OUT = 0, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the outputs follow `in_bcd` in the same cycle.
- R8: With REG_OUT = 1, an operand accepted at a clock edge is presented, recoded, from the next cycle on. `in_ready` is high when the stage is empty or `out_ready` is high. A presented result and its valid stay unchanged while `out_ready` is low.
- R9: With REG_OUT = 1, `out_valid` is 0 while reset is asserted and after its release until an operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present on `in_bcd` |
| in_ready | output | 1 | Block accepts an operand this cycle |
| in_bcd | input | 4*DIGITS | BCD multiplier operand, digit 0 in bits 3..0 |
| out_valid | output | 1 | Recoded result present |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_mag | output | 5*(DIGITS+1) | One-hot magnitude selects, 5 bits per recoded digit |
| out_neg | output | DIGITS+1 | Sign per recoded digit, 1 = negative |
| out_bad | output | DIGITS | Input digit coded outside 0..9 |

## Verification
Some properties are checked on every clock by assertions. Each magnitude field must stay one-hot or zero, and a set sign must never sit on a zero field. The top digit must never be negative or larger than one. A flagged digit must select nothing. Inside the register stage, a stalled result must not change, and an accepted operand must appear on the next cycle. Other properties need the bench's reference model, run over directed and random operands. These are the exact digit values and the transfer pattern, including carries through runs of nines and fives. The bench also checks that the weighted sum rebuilds the operand, that no result is lost or duplicated under random back-pressure, and the reset state.

// File: rtl/sdr10_pkg.sv
package sdr10_pkg;
  localparam int BCD_W = 4;
  localparam int MAG_W = 5;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [MAG_W-1:0] mag_t;

  // transfer out of a digit: set for codes 5 and up (invalid codes included)
  function automatic logic xfer_of(input bcd_t y);
    return y[3] | (y[2] & (y[1] | y[0]));
  endfunction
endpackage

// File: rtl/sdr10_digit.sv
module sdr10_digit
  import sdr10_pkg::*;
(
  input  bcd_t dig_in,
  input  logic xfer_in,
  output logic xfer_out,
  output mag_t mag,
  output logic neg,
  output logic bad
);
  logic [4:0] y_ext;
  logic [4:0] abs_val;

  assign xfer_out = xfer_of(dig_in);
  assign bad      = (dig_in > 4'd9);
  assign y_ext    = {1'b0, dig_in};

  // absolute value of y + xfer_in - 10*xfer_out
  always_comb begin
    if (xfer_out) abs_val = 5'd10 - y_ext - {4'b0, xfer_in};
    else          abs_val = y_ext + {4'b0, xfer_in};
  end

  always_comb begin
    mag = '0;
    if (!bad) begin
      case (abs_val)
        5'd1:    mag = 5'b00001;
        5'd2:    mag = 5'b00010;
        5'd3:    mag = 5'b00100;
        5'd4:    mag = 5'b01000;
        5'd5:    mag = 5'b10000;
        default: mag = 5'b00000;
      endcase
    end
  end

  // negative only for a real nonzero digit that gave a transfer away
  assign neg = xfer_out & ~bad & (abs_val != 5'd0);
endmodule

// File: rtl/sdr10_pipe.sv
module sdr10_pipe #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (in_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end

      AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("stall hold"); // R8

      AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data))) else $error("accept"); // R8
    end else begin : g_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/sdr10_recoder.sv
module sdr10_recoder
  import sdr10_pkg::*;
#(
  parameter int DIGITS  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [BCD_W*DIGITS-1:0]      in_bcd,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [MAG_W*(DIGITS+1)-1:0]  out_mag,
  output logic [DIGITS:0]              out_neg,
  output logic [DIGITS-1:0]            out_bad
);
  localparam int OUT_D  = DIGITS + 1;
  localparam int MAG_TW = MAG_W * OUT_D;
  localparam int PW     = MAG_TW + OUT_D + DIGITS;

  logic [DIGITS:0]       xfer;
  logic [MAG_TW-1:0]     raw_mag;
  logic [DIGITS:0]       raw_neg;
  logic [DIGITS-1:0]     raw_bad;
  logic                  top_xfer_unused;
  logic                  top_bad_unused;
  logic [PW-1:0]         pipe_out;

  assign xfer[0] = 1'b0;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      sdr10_digit u_dig (
        .dig_in   (in_bcd[BCD_W*i +: BCD_W]),
        .xfer_in  (xfer[i]),
        .xfer_out (xfer[i+1]),
        .mag      (raw_mag[MAG_W*i +: MAG_W]),
        .neg      (raw_neg[i]),
        .bad      (raw_bad[i])
      );
    end
  endgenerate

  // extra top digit: a zero digit receiving the last transfer
  sdr10_digit u_top (
    .dig_in   ('0),
    .xfer_in  (xfer[DIGITS]),
    .xfer_out (top_xfer_unused),
    .mag      (raw_mag[MAG_W*DIGITS +: MAG_W]),
    .neg      (raw_neg[DIGITS]),
    .bad      (top_bad_unused)
  );

  sdr10_pipe #(.W(PW), .REG_OUT(REG_OUT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({raw_bad, raw_neg, raw_mag}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pipe_out)
  );

  assign out_mag = pipe_out[MAG_TW-1:0];
  assign out_neg = pipe_out[MAG_TW +: OUT_D];
  assign out_bad = pipe_out[MAG_TW+OUT_D +: DIGITS];

  generate
    for (genvar i = 0; i < OUT_D; i++) begin : g_chk
      AST_MAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_mag[MAG_W*i +: MAG_W])) else $error("mag onehot"); // R2
      AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_neg[i] |-> (out_mag[MAG_W*i +: MAG_W] != '0)) else $error("neg zero"); // R3
    end
    for (genvar i = 0; i < DIGITS; i++) begin : g_bad
      AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad[i] |-> (out_mag[MAG_W*i +: MAG_W] == '0 && !out_neg[i])) else $error("bad"); // R6
    end
  endgenerate

  AST_TOP_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_neg[DIGITS] && out_mag[MAG_W*DIGITS +: MAG_W] <= 5'd1)) else $error("top"); // R4
endmodule

// File: tb/sim_sdr10_recoder.sv
module sim_sdr10_recoder;
  localparam int D  = 16;
  localparam int MW = 5 * (D + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic rdy = 1'b0;
  logic [4*D-1:0] in_bcd = '0;

  logic u0_in_ready, u0_out_valid;
  logic [MW-1:0] u0_mag;
  logic [D:0] u0_neg;
  logic [D-1:0] u0_bad;
  logic u1_in_ready, u1_out_valid;
  logic [MW-1:0] u1_mag;
  logic [D:0] u1_neg;
  logic [D-1:0] u1_bad;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [4*D-1:0] q[$];
  bit hold_prev = 1'b0;
  logic [MW+2*D:0] held;

  always #4 clk = ~clk; // 125 MHz

  sdr10_recoder #(.DIGITS(D), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(u0_in_ready),
    .in_bcd(in_bcd), .out_valid(u0_out_valid), .out_ready(rdy),
    .out_mag(u0_mag), .out_neg(u0_neg), .out_bad(u0_bad));

  sdr10_recoder #(.DIGITS(D), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(u1_in_ready),
    .in_bcd(in_bcd), .out_valid(u1_out_valid), .out_ready(rdy),
    .out_mag(u1_mag), .out_neg(u1_neg), .out_bad(u1_bad));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: per-digit signed values and flags
  task automatic ref_calc(input logic [4*D-1:0] bcd, output int v[D+1],
                          output logic [D-1:0] bad);
    int tin = 0;
    for (int i = 0; i <= D; i++) begin
      int y = (i < D) ? int'(bcd[4*i +: 4]) : 0;
      int t = (y >= 5) ? 1 : 0;
      v[i] = y + tin - 10 * t;
      if (i < D) begin
        bad[i] = (y > 9);
        if (y > 9) v[i] = 0;
      end
      tin = t;
    end
  endtask

  function automatic int dec_digit(input logic [4:0] m, input logic n);
    int a = 0;
    for (int k = 0; k < 5; k++) if (m[k]) a = k + 1;
    return n ? -a : a;
  endfunction

  task automatic compare(input logic [MW-1:0] mag, input logic [D:0] neg,
                         input logic [D-1:0] bad, input logic [4*D-1:0] bcd,
                         input string tag);
    int v[D+1];
    logic [D-1:0] ebad;
    logic [MW-1:0] emag;
    logic [D:0] eneg;
    longint sum, want, p;
    bit dig_ok;
    ref_calc(bcd, v, ebad);
    emag = '0; eneg = '0; dig_ok = 1'b1;
    for (int i = 0; i <= D; i++) begin
      int a = (v[i] < 0) ? -v[i] : v[i];
      if (a != 0) emag[5*i + a - 1] = 1'b1;
      eneg[i] = (v[i] < 0);
      if (!(i < D && ebad[i]) && dec_digit(mag[5*i +: 5], neg[i]) != v[i]) dig_ok = 1'b0;
    end
    chk(dig_ok, "R1", {tag, " digit values"}, 128'(mag), 128'(emag));
    chk(mag == emag, "R2", {tag, " magnitude"}, 128'(mag), 128'(emag));
    chk(neg == eneg, "R3", {tag, " sign"}, 128'(neg), 128'(eneg));
    chk(mag[5*D +: 5] == emag[5*D +: 5] && !neg[D], "R4", {tag, " top digit"},
        128'({neg[D], mag[5*D +: 5]}), 128'(emag[5*D +: 5]));
    chk(bad == ebad, "R6", {tag, " bad flags"}, 128'(bad), 128'(ebad));
    if (ebad == '0) begin
      sum = 0; want = 0; p = 1;
      for (int i = 0; i <= D; i++) begin
        sum += longint'(dec_digit(mag[5*i +: 5], neg[i])) * p;
        if (i < D) want += longint'(bcd[4*i +: 4]) * p;
        p *= 10;
      end
      chk(sum == want, "R5", {tag, " weighted sum"}, 128'(sum), 128'(want));
    end
  endtask

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (in_valid) compare(u1_mag, u1_neg, u1_bad, in_bcd, "comb");
      chk(u1_out_valid == in_valid && u1_in_ready == rdy, "R7", "comb handshake",
          128'({u1_out_valid, u1_in_ready}), 128'({in_valid, rdy}));
      chk(u0_in_ready == (!u0_out_valid || rdy), "R8", "ready rule",
          128'(u0_in_ready), 128'(!u0_out_valid || rdy));
      if (hold_prev)
        chk(u0_out_valid && {u0_bad, u0_neg, u0_mag} == held, "R8", "stall hold",
            128'({u0_bad, u0_neg, u0_mag}), 128'(held));
      if (u0_out_valid && rdy) begin
        if (q.size() == 0) chk(1'b0, "R8", "spurious result", 128'(1), 128'(0));
        else compare(u0_mag, u0_neg, u0_bad, q.pop_front(), "reg");
      end
      if (in_valid && u0_in_ready) q.push_back(in_bcd);
      hold_prev = u0_out_valid && !rdy;
      held = {u0_bad, u0_neg, u0_mag};
    end
  end

  task automatic send(input logic [4*D-1:0] bcd);
    bit taken = 1'b0;
    in_bcd = bcd; in_valid = 1'b1;
    while (!taken) begin
      @(negedge clk); taken = u0_in_ready;
      @(posedge clk); #2;
    end
    in_valid = 1'b0;
    if ($urandom_range(0, 3) == 0) begin @(posedge clk); #2; end
  endtask

  function automatic logic [4*D-1:0] rand_bcd(input bit allow_bad);
    logic [4*D-1:0] r;
    for (int i = 0; i < D; i++) r[4*i +: 4] = 4'($urandom_range(0, 9));
    if (allow_bad && $urandom_range(0, 7) == 0)
      r[4*$urandom_range(0, D-1) +: 4] = 4'($urandom_range(10, 15));
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(u0_out_valid == 1'b0, "R9", "valid in reset", 128'(u0_out_valid), 128'(0));
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(u0_out_valid == 1'b0, "R9", "valid after reset", 128'(u0_out_valid), 128'(0));
    @(posedge clk); #2;
    fork
      forever begin @(posedge clk); #2 rdy = ($urandom_range(0, 3) != 0); end
    join_none
    send(64'h0000000000000000);
    send(64'h9999999999999999);
    send(64'h5555555555555555);
    send(64'h4444444444444444);
    send(64'h0123456789012345);
    send(64'h9876543210987654);
    send(64'h5050505050505050);
    send(64'h4949494949494949);
    send(64'h9000000000000000);
    send(64'h00000000000000A0); // R6 invalid code
    send(64'hF5F5F5F5F5F5F5F5);
    for (int n = 0; n < 400; n++) send(rand_bcd(1'b1));
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=<50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule